// File: doc/BRIEF.md
# Ethernet Destination Address Hash Filter

This block sits next to a receive path and decides whether an incoming frame is kept, based only on its 48-bit destination address. The receive path sends the address one byte per valid beat, with a start marker on the first byte. The block builds a 6-bit hash index as the bytes arrive. It does this by XOR-folding every sixth address bit together. It then looks that index up in a 64-bit hash table.

A set of configuration inputs qualifies the table hit: separate hash enables for unicast and multicast, a broadcast disable, and a copy-all (promiscuous) control. The table is loaded and read back as two 32-bit words. One cycle after the sixth address byte, the block presents an accept flag and a match-type code. Both stay valid until the next start marker.

Top module: `eth_hash_filter`

## Requirements
- R1: The hash index bit i (i = 0..5) is the XOR of address bits i, i+6, i+12, i+18, i+24, i+30, i+36 and i+42. Address bit 0 is the least significant bit of the first received byte, and bit 47 is the most significant bit of the sixth byte.
- R2: The 64-bit table is reached through `tbl_sel`. Value 0 selects table bits 31:0 and value 1 selects bits 63:32. A write with `tbl_we` high replaces only the selected word. `tbl_rdata` shows the selected word combinationally.
- R3: When address bit 0 is 1, the multicast hash enable is set and the indexed table bit is 1, the frame is accepted with kind 2 (multicast hash). With all table bits set and multicast hash enabled, every multicast address is accepted.
- R4: When address bit 0 is 0, the unicast hash enable is set and the indexed table bit is 1, the frame is accepted with kind 1 (unicast hash). Any other hash case gives reject with kind 0.
- R5: An all-ones destination, with copy-all off, is accepted with kind 3 (broadcast) when broadcast disable is clear. It is rejected with kind 0 when broadcast disable is set, whatever the table holds.
- R6: With copy-all set, every frame is accepted with kind 4 (copy-all). This takes priority over every other case.
- R7: `dec_valid` rises on the clock edge that samples the sixth byte. It stays high with a constant decision until a start-marked byte arrives. The start-marked byte clears it at that same edge.
- R8: Bytes after the sixth, and bytes not preceded by a start marker since reset, do not change the decision.
- R9: The table and the configuration inputs are sampled at the edge that takes the sixth byte. Later changes do not alter the decision being held.
- R10: After reset the table is all zeros and `dec_valid`, `dec_accept` and `dec_kind` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Address byte valid |
| rx_sof | input | 1 | Marks the first address byte (qualified by rx_valid) |
| rx_byte | input | 8 | Address byte, first byte first |
| tbl_we | input | 1 | Table word write strobe |
| tbl_sel | input | 1 | Table word select (0 = bits 31:0, 1 = bits 63:32) |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Selected table word |
| cfg_uc_hash_en | input | 1 | Unicast hash enable |
| cfg_mc_hash_en | input | 1 | Multicast hash enable |
| cfg_bcast_dis | input | 1 | Reject all-ones destination |
| cfg_copy_all | input | 1 | Accept every frame |
| dec_valid | output | 1 | Decision available |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 3 | 0 none, 1 unicast hash, 2 multicast hash, 3 broadcast, 4 copy-all |

## Verification
The bench sweeps all 64 table positions, using addresses whose fold is known. In each case it sets the target bit, and separately only its neighbour bit. A wrong bit-to-index mapping would accept on the neighbour or miss the target. The bench also feeds many pseudo-random addresses against a model that folds all 48 bits at once, catching a wrong per-byte bit offset.

An all-ones address is tried under every enable combination. A design that lets the multicast hash decide this address would accept it while broadcast disable is set. Other targeted cases:
- Writes to the table after the decision. A design that reads the table live would flip a decision it should hold.
- Trailing bytes after the sixth. A design that keeps folding would change its decision.
- Stray bytes before any start marker. A design that does not guard against them would raise a decision.

// File: rtl/eth_hash_filter.sv
module eth_hash_filter #(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tbl_we,
  input  logic              tbl_sel,
  input  logic [WORD_W-1:0] tbl_wdata,
  output logic [WORD_W-1:0] tbl_rdata,
  input  logic              cfg_uc_hash_en,
  input  logic              cfg_mc_hash_en,
  input  logic              cfg_bcast_dis,
  input  logic              cfg_copy_all,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [2:0]        dec_kind
);
  localparam int TBL_BITS = 1 << IDX_W;
  localparam int CNT_W    = $clog2(ADDR_BYTES + 1);
  localparam logic [2:0] K_NONE = 3'd0, K_UC = 3'd1, K_MC = 3'd2, K_BC = 3'd3, K_ALL = 3'd4;

  logic [TBL_BITS-1:0] tbl;
  logic [CNT_W-1:0]    cnt;
  logic [IDX_W-1:0]    idx_acc;
  logic                is_mc, all_ones;

  function automatic logic [IDX_W-1:0] fold_byte(input logic [BYTE_W-1:0] b, input logic [CNT_W-1:0] pos);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int j = 0; j < BYTE_W; j++)
      r[(int'(pos) * BYTE_W + j) % IDX_W] ^= b[j];
    return r;
  endfunction

  logic [CNT_W-1:0] pos;
  logic             beat, last, nmc, nones, hit;
  logic [IDX_W-1:0] nidx;
  logic [2:0]       kind;

  assign pos   = rx_sof ? '0 : cnt;
  assign beat  = rx_valid && (rx_sof || cnt < CNT_W'(ADDR_BYTES));
  assign last  = beat && pos == CNT_W'(ADDR_BYTES - 1);
  assign nidx  = (rx_sof ? '0 : idx_acc) ^ fold_byte(rx_byte, pos);
  assign nmc   = rx_sof ? rx_byte[0] : is_mc;
  assign nones = (rx_sof ? 1'b1 : all_ones) & (&rx_byte);
  assign hit   = tbl[nidx];

  always_comb begin
    if (cfg_copy_all)                      kind = K_ALL;
    else if (nones)                        kind = cfg_bcast_dis ? K_NONE : K_BC;
    else if (nmc && cfg_mc_hash_en && hit) kind = K_MC;
    else if (!nmc && cfg_uc_hash_en && hit) kind = K_UC;
    else                                   kind = K_NONE;
  end

  assign tbl_rdata = tbl[int'(tbl_sel) * WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl        <= '0;
      cnt        <= CNT_W'(ADDR_BYTES);
      idx_acc    <= '0;
      is_mc      <= 1'b0;
      all_ones   <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_kind   <= K_NONE;
    end else begin
      if (tbl_we) tbl[int'(tbl_sel) * WORD_W +: WORD_W] <= tbl_wdata;
      if (beat) begin
        idx_acc  <= nidx;
        cnt      <= pos + CNT_W'(1);
        is_mc    <= nmc;
        all_ones <= nones;
        if (rx_sof) dec_valid <= 1'b0;
        if (last) begin
          dec_valid  <= 1'b1;
          dec_kind   <= kind;
          dec_accept <= kind != K_NONE;
        end
      end
    end
  end

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(ADDR_BYTES));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !(rx_valid && rx_sof) |=> dec_valid && $stable(dec_kind) && $stable(dec_accept));

  a_r7_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sof && ADDR_BYTES > 1 |=> !dec_valid);

  a_r7_rise_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(rx_valid));

  a_r6_copy_all: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && $past(cfg_copy_all) |-> dec_accept && dec_kind == K_ALL);

  a_r2_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we && !tbl_sel |=> tbl[WORD_W-1:0] == $past(tbl_wdata));
endmodule

// File: tb/eth_hash_filter_test.sv
module eth_hash_filter_test;
  logic        clk = 0, rst_n = 0;
  logic        rx_valid = 0, rx_sof = 0;
  logic [7:0]  rx_byte = 0;
  logic        tbl_we = 0, tbl_sel = 0;
  logic [31:0] tbl_wdata = 0, tbl_rdata;
  logic        uc_en = 0, mc_en = 0, bc_dis = 0, copy_all = 0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_kind;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  eth_hash_filter uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
    .cfg_uc_hash_en(uc_en), .cfg_mc_hash_en(mc_en), .cfg_bcast_dis(bc_dis),
    .cfg_copy_all(copy_all), .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_kind(dec_kind));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    rng ^= rng << 13; rng ^= rng >> 7; rng ^= rng << 17;
    return rng;
  endfunction

  function automatic logic [5:0] ref_fold(input logic [47:0] a);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) begin
      r[i] = 1'b0;
      for (int m = 0; m < 8; m++) r[i] ^= a[i + 6*m];
    end
    return r;
  endfunction

  function automatic logic [2:0] ref_kind(input logic [47:0] a, input logic [63:0] t);
    if (copy_all) return 3'd4;
    if (&a) return bc_dis ? 3'd0 : 3'd3;
    if (a[0] && mc_en && t[ref_fold(a)]) return 3'd2;
    if (!a[0] && uc_en && t[ref_fold(a)]) return 3'd1;
    return 3'd0;
  endfunction

  task automatic write_word(input bit sel, input logic [31:0] d);
    @(negedge clk); tbl_we = 1; tbl_sel = sel; tbl_wdata = d;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic load_table(input logic [63:0] t);
    write_word(0, t[31:0]);
    write_word(1, t[63:32]);
  endtask

  task automatic send_addr(input logic [47:0] a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (k == 0); rx_byte = a[8*k +: 8];
      if (k == 5) check(dec_valid == 0, "R7 cleared by start", dec_valid, 0);
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0;
  endtask

  task automatic frame_check(input logic [47:0] a, input logic [63:0] t, input string req);
    logic [2:0] k;
    k = ref_kind(a, t);
    send_addr(a);
    check(dec_valid == 1, req, dec_valid, 1);
    check(dec_kind == k && dec_accept == (k != 0), req, {dec_accept, dec_kind}, {k != 0, k});
  endtask

  initial begin
    logic [63:0] t;
    logic [47:0] a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(dec_valid == 0 && dec_accept == 0 && dec_kind == 0, "R10 outputs", {dec_valid, dec_accept, dec_kind}, 0);
    tbl_sel = 0; #1 check(tbl_rdata == 0, "R10 table low", tbl_rdata, 0);
    tbl_sel = 1; #1 check(tbl_rdata == 0, "R10 table high", tbl_rdata, 0);

    // R8 stray bytes with no start marker since reset
    uc_en = 1; mc_en = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); rx_valid = 1; rx_byte = 8'hFF;
    end
    @(negedge clk); rx_valid = 0;
    check(dec_valid == 0, "R8 stray bytes", dec_valid, 0);

    // R2 word access
    write_word(0, 32'hA5A5_0F0F);
    write_word(1, 32'h1234_5678);
    tbl_sel = 0; #1 check(tbl_rdata == 32'hA5A5_0F0F, "R2 low word", tbl_rdata, 32'hA5A5_0F0F);
    tbl_sel = 1; #1 check(tbl_rdata == 32'h1234_5678, "R2 high word", tbl_rdata, 32'h1234_5678);
    write_word(0, 32'h0);
    tbl_sel = 1; #1 check(tbl_rdata == 32'h1234_5678, "R2 other word kept", tbl_rdata, 32'h1234_5678);

    // R1 exhaustive index sweep (target bit, then neighbour bit only)
    uc_en = 1; mc_en = 1; bc_dis = 0; copy_all = 0;
    for (int i = 0; i < 64; i++) begin
      a = {42'h155_5555_5540 >> 2, 6'(i)} ^ {6'(i), 42'h0} ^ {6'(i), 42'h0};
      a = {36'h0, 6'(i), 6'(i)} ^ {36'h0, 6'(i), 6'h0};
      t = 64'd1 << i;
      load_table(t);
      frame_check(a, t, "R1 fold target");
      t = 64'd1 << (i ^ 1);
      load_table(t);
      frame_check(a, t, "R1 fold neighbour");
    end

    // R3 all-ones table accepts every multicast; R4 unicast gated off
    t = '1; load_table(t);
    uc_en = 0; mc_en = 1;
    for (int n = 0; n < 20; n++) begin
      a = next_rand(); a[0] = 1'b1; a[47] = 1'b0;
      frame_check(a, t, "R3 multicast all-ones table");
      a[0] = 1'b0;
      frame_check(a, t, "R4 unicast disabled");
    end
    uc_en = 1; mc_en = 0;
    a = 48'h0000_0000_0002;
    frame_check(a, t, "R4 unicast hit");
    a = 48'h0000_0000_0003;
    frame_check(a, t, "R3 multicast disabled");

    // R5 / R6 all-ones destination under every enable combination
    for (int c = 0; c < 16; c++) begin
      {copy_all, bc_dis, mc_en, uc_en} = 4'(c);
      frame_check(48'hFFFF_FFFF_FFFF, t, copy_all ? "R6 copy-all broadcast" : "R5 broadcast");
    end
    copy_all = 1; bc_dis = 1; uc_en = 0; mc_en = 0;
    load_table(64'h0);
    frame_check(48'h0000_0000_1234, 64'h0, "R6 copy-all unicast");
    copy_all = 0;

    // R9 table change after decision; R8 trailing bytes
    uc_en = 1; mc_en = 1; bc_dis = 0;
    a = 48'h0000_0000_0010;
    t = 64'd1 << ref_fold(a);
    load_table(t);
    frame_check(a, t, "R4 unicast before hold");
    load_table(64'h0);
    uc_en = 0; copy_all = 1;
    check(dec_valid && dec_accept && dec_kind == 1, "R9 held after table/config change", {dec_valid, dec_accept, dec_kind}, 3'h1 | 5'h18);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_byte = 8'hFF;
    end
    @(negedge clk); rx_valid = 0;
    check(dec_valid && dec_accept && dec_kind == 1, "R8 trailing bytes", {dec_valid, dec_accept, dec_kind}, 3'h1 | 5'h18);
    copy_all = 0;

    // R1/R3/R4/R5/R6 pseudo-random sweep against the direct fold
    for (int n = 0; n < 300; n++) begin
      t = next_rand(); load_table(t);
      {copy_all, bc_dis, mc_en, uc_en} = 4'(next_rand());
      if (copy_all && n[0]) copy_all = 0;
      a = next_rand();
      if (n % 9 == 0) a = '1;
      frame_check(a, t, "R1 random frame");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule